// File: doc/BRIEF.md
# Letterbox Viewport Size Calculator

This block works out the width and height of the output viewport that a display scaler should fill. It is given the source image size, the timing size of the output mode, a scaling mode, an underscan enable and two border values. It first shrinks the output rectangle to compensate for overscan. It then applies either centred placement or aspect-preserving fitting to what is left. Each dimension that must be recomputed uses a rounded fixed-point ratio with 19 fractional bits, and a bit-serial restoring divider produces that ratio.

A caller presents all operands and pulses `start` for one cycle. The block captures the operands on that edge and raises `busy`. When the result is ready it pulses `done` for one cycle with the final size on `view_w` and `view_h`. Frame-packed stereo input is handled by counting both eyes in the source height. A zero divisor never stalls the divider.

Top module: `vfit_viewport`

## Requirements
- R1: `scale_mode` encodes 0 = none, 1 = fullscreen, 2 = centre, 3 = aspect. `force_full` = 1 treats any mode as fullscreen. With mode none and `force_full` = 0, the starting output size is the source size. Otherwise the starting output size is `mode_w` x `mode_h`. Neither none nor fullscreen changes the size after underscan.
- R2: With `pack3d` = 1, the source height is `in_h + in_vtotal` (17 bits). With `pack3d` = 0, the source height is `in_h`.
- R3: With `underscan` = 1, the width is reduced by 2*`border_h` when `border_h` is nonzero, and by floor(w/16)+32 when it is zero. The result saturates at 0.
- R4: With `underscan` = 1 and a nonzero `border_v`, the height is reduced by 2*`border_v`, saturating at 0. With a zero `border_v`, the height becomes (w'*r + floor(r/2)) >> 19, where r = floor((h<<19)/w) is taken with the width w from before the reduction and w' is the reduced width.
- R5: In centre mode, each output dimension becomes the minimum of the source dimension and the current output dimension.
- R6: In aspect mode, when oW*iH > iW*oH the width becomes (oH*r + floor(r/2)) >> 19 with r = floor((iW<<19)/iH). Otherwise the height becomes (oW*r + floor(r/2)) >> 19 with r = floor((iH<<19)/iW). Results are kept to 17 bits.
- R7: Centre and aspect adjustments act on the size left after underscan compensation.
- R8: When a ratio divisor is zero, the dimension that ratio would set is left unchanged, and `done` is still raised.
- R9: `done` is a single-cycle pulse. Counting the `start` edge as edge 1, it is high after edge 3. Each nonzero-divisor ratio adds 37 cycles to this, and each zero-divisor ratio adds 1 cycle.
- R10: Operands are sampled only on the accepted `start` edge. A `start` while `busy` is ignored. `view_w`/`view_h` stay stable from `done` until the next accepted `start`.
- R11: After reset, `busy` = 0, `done` = 0, `view_w` = 0 and `view_h` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (accepted when idle) |
| in_w | input | 16 | Source image width |
| in_h | input | 16 | Source image display height |
| in_vtotal | input | 16 | Source vertical total, added for stereo packing |
| pack3d | input | 1 | Source is frame-packed stereo |
| mode_w | input | 16 | Output mode active width |
| mode_h | input | 16 | Output mode active height |
| scale_mode | input | 2 | 0 none, 1 fullscreen, 2 centre, 3 aspect |
| force_full | input | 1 | Force fullscreen behaviour |
| underscan | input | 1 | Enable overscan compensation |
| border_h | input | 16 | Horizontal border (0 = automatic) |
| border_v | input | 16 | Vertical border (0 = keep ratio) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| view_w | output | 17 | Resulting viewport width |
| view_h | output | 17 | Resulting viewport height |

## Verification
Result timing depends on how many ratios a case needs. A case with no division reports `done` three cycles after the start edge. Each nonzero-divisor ratio adds 37 cycles and each zero-divisor ratio adds one. The bench model derives both the final size and this latency from the operands. It then compares `done` against the predicted cycle on every clock of the transaction, and reads the size on the predicted `done` cycle. It also rechecks the size three idle cycles later, and alters the operands (and pulses `start`) while busy, to show that only the captured operands matter.

// File: rtl/vfit_pkg.sv
package vfit_pkg;

  typedef enum logic [1:0] {
    SCL_NONE   = 2'd0,
    SCL_FULL   = 2'd1,
    SCL_CENTER = 2'd2,
    SCL_ASPECT = 2'd3
  } scl_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UND,
    ST_UND_WAIT,
    ST_FIT,
    ST_ASP_WAIT,
    ST_DONE
  } fit_state_e;

endpackage

// File: rtl/vfit_divider.sv
module vfit_divider #(
  parameter int NUM_W = 36,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             zero_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q, rem_nx;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, zero_q;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  always_comb begin
    trial  = {rem_q, quo_q[NUM_W-1]};
    diff   = trial - {1'b0, den_q};
    fits   = trial >= {1'b0, den_q};
    rem_nx = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        if (den_i == '0) begin
          done_q <= 1'b1;
          zero_q <= 1'b1;
          quo_q  <= '0;
        end else begin
          den_q  <= den_i;
          quo_q  <= num_i;
          rem_q  <= '0;
          cnt_q  <= CNT_W'(NUM_W);
          busy_q <= 1'b1;
          zero_q <= 1'b0;
        end
      end else if (busy_q) begin
        rem_q <= rem_nx;
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign zero_o = zero_q;
  assign quo_o  = quo_q;

  // R8: a zero divisor answers on the very next cycle, flagged
  a_r8_zero_div_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !busy_o && den_i == '0) |=> (done_o && zero_o));

  // R9: only one ratio in flight at a time
  a_r9_div_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_o);
endmodule

// File: rtl/vfit_underscan.sv
module vfit_underscan #(
  parameter int DIM_W = 16
) (
  input  logic [DIM_W:0]   cur_w,
  input  logic [DIM_W:0]   cur_h,
  input  logic [DIM_W-1:0] hb,
  input  logic [DIM_W-1:0] vb,
  output logic [DIM_W:0]   new_w,
  output logic [DIM_W:0]   new_h,
  output logic             vb_set
);
  localparam int OUT_W = DIM_W + 1;

  logic [OUT_W-1:0] dec_w, dec_h;

  always_comb begin
    dec_w  = (hb != '0) ? {hb, 1'b0} : (cur_w >> 4) + OUT_W'(32);
    dec_h  = {vb, 1'b0};
    new_w  = (cur_w > dec_w) ? cur_w - dec_w : '0;
    new_h  = (cur_h > dec_h) ? cur_h - dec_h : '0;
    vb_set = (vb != '0);
  end
endmodule

// File: rtl/vfit_fit_sel.sv
module vfit_fit_sel #(
  parameter int OUT_W  = 17,
  parameter int FRAC_W = 19
) (
  input  logic [OUT_W-1:0]        cw,
  input  logic [OUT_W-1:0]        ch,
  input  logic [OUT_W-1:0]        iw,
  input  logic [OUT_W-1:0]        ih,
  output logic                    widen,
  output logic [OUT_W-1:0]        min_w,
  output logic [OUT_W-1:0]        min_h,
  output logic [OUT_W+FRAC_W-1:0] num,
  output logic [OUT_W-1:0]        den
);
  localparam int PW = 2 * OUT_W;

  logic [PW-1:0] out_cross, in_cross;

  always_comb begin
    out_cross = PW'(cw) * PW'(ih);
    in_cross  = PW'(iw) * PW'(ch);
    widen     = out_cross > in_cross;
    min_w     = (iw < cw) ? iw : cw;
    min_h     = (ih < ch) ? ih : ch;
    num       = widen ? {iw, {FRAC_W{1'b0}}} : {ih, {FRAC_W{1'b0}}};
    den       = widen ? ih : iw;
  end
endmodule

// File: rtl/vfit_viewport.sv
module vfit_viewport #(
  parameter int DIM_W  = 16,
  parameter int FRAC_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] in_w,
  input  logic [DIM_W-1:0] in_h,
  input  logic [DIM_W-1:0] in_vtotal,
  input  logic             pack3d,
  input  logic [DIM_W-1:0] mode_w,
  input  logic [DIM_W-1:0] mode_h,
  input  logic [1:0]       scale_mode,
  input  logic             force_full,
  input  logic             underscan,
  input  logic [DIM_W-1:0] border_h,
  input  logic [DIM_W-1:0] border_v,
  output logic             busy,
  output logic             done,
  output logic [DIM_W:0]   view_w,
  output logic [DIM_W:0]   view_h
);
  import vfit_pkg::*;

  localparam int OUT_W  = DIM_W + 1;
  localparam int NUM_W  = OUT_W + FRAC_W;
  localparam int PROD_W = OUT_W + NUM_W;

  // rounded fixed-point scale: (a*r + r/2) >> FRAC_W
  function automatic logic [OUT_W-1:0] round_scale(input logic [OUT_W-1:0] a,
                                                   input logic [NUM_W-1:0] r);
    logic [PROD_W-1:0] p;
    p = PROD_W'(a) * PROD_W'(r) + PROD_W'(r >> 1);
    return OUT_W'(p >> FRAC_W);
  endfunction

  fit_state_e       st;
  scl_mode_e        md_q;
  logic [OUT_W-1:0] cw, ch, iw_q, ih_q;
  logic [DIM_W-1:0] bx_q, by_q;
  logic             und_q, asp_w_q;

  // capture-side values
  logic [OUT_W-1:0] ih_src;
  logic             use_src;
  scl_mode_e        md_eff;

  always_comb begin
    ih_src  = pack3d ? OUT_W'(in_h) + OUT_W'(in_vtotal) : OUT_W'(in_h);
    use_src = !force_full && (scale_mode == SCL_NONE);
    md_eff  = force_full ? SCL_FULL : scl_mode_e'(scale_mode);
  end

  // underscan stage
  logic [OUT_W-1:0] us_w, us_h;
  logic             us_vb_set;

  vfit_underscan #(.DIM_W(DIM_W)) u_und (
    .cur_w(cw), .cur_h(ch), .hb(bx_q), .vb(by_q),
    .new_w(us_w), .new_h(us_h), .vb_set(us_vb_set)
  );

  // centre / aspect selection
  logic             fs_widen;
  logic [OUT_W-1:0] fs_min_w, fs_min_h, fs_den;
  logic [NUM_W-1:0] fs_num;

  vfit_fit_sel #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_sel (
    .cw(cw), .ch(ch), .iw(iw_q), .ih(ih_q),
    .widen(fs_widen), .min_w(fs_min_w), .min_h(fs_min_h),
    .num(fs_num), .den(fs_den)
  );

  // shared ratio divider
  logic             div_go, div_busy, div_done, div_zero;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [OUT_W-1:0] div_den;
  logic             und_ratio_evt, asp_ratio_evt;

  always_comb begin
    und_ratio_evt = (st == ST_UND) && und_q && !us_vb_set;
    asp_ratio_evt = (st == ST_FIT) && (md_q == SCL_ASPECT);
    div_go        = und_ratio_evt || asp_ratio_evt;
    div_num       = und_ratio_evt ? {ch, {FRAC_W{1'b0}}} : fs_num;
    div_den       = und_ratio_evt ? cw : fs_den;
  end

  vfit_divider #(.NUM_W(NUM_W), .DEN_W(OUT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(div_num), .den_i(div_den),
    .busy_o(div_busy), .done_o(div_done), .zero_o(div_zero), .quo_o(div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      md_q    <= SCL_NONE;
      cw      <= '0;
      ch      <= '0;
      iw_q    <= '0;
      ih_q    <= '0;
      bx_q    <= '0;
      by_q    <= '0;
      und_q   <= 1'b0;
      asp_w_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          iw_q  <= OUT_W'(in_w);
          ih_q  <= ih_src;
          cw    <= use_src ? OUT_W'(in_w) : OUT_W'(mode_w);
          ch    <= use_src ? ih_src : OUT_W'(mode_h);
          md_q  <= md_eff;
          und_q <= underscan;
          bx_q  <= border_h;
          by_q  <= border_v;
          st    <= ST_UND;
        end
        ST_UND: begin
          if (und_q) begin
            cw <= us_w;
            if (us_vb_set) begin
              ch <= us_h;
              st <= ST_FIT;
            end else begin
              st <= ST_UND_WAIT;
            end
          end else begin
            st <= ST_FIT;
          end
        end
        ST_UND_WAIT: if (div_done) begin
          if (!div_zero) ch <= round_scale(cw, div_quo);
          st <= ST_FIT;
        end
        ST_FIT: begin
          if (md_q == SCL_CENTER) begin
            cw <= fs_min_w;
            ch <= fs_min_h;
            st <= ST_DONE;
          end else if (md_q == SCL_ASPECT) begin
            asp_w_q <= fs_widen;
            st      <= ST_ASP_WAIT;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_ASP_WAIT: if (div_done) begin
          if (!div_zero) begin
            if (asp_w_q) cw <= round_scale(ch, div_quo);
            else         ch <= round_scale(cw, div_quo);
          end
          st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_DONE);
  assign view_w = cw;
  assign view_h = ch;

  // R9: done lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: result holds while idle and no start arrives
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(view_w) && $stable(view_h)));

  // R3: underscan never grows the width
  a_r3_under_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UND && und_q) |=> (view_w <= $past(view_w)));

  // R5: centre placement is bounded by the source size
  a_r5_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIT && md_q == SCL_CENTER) |=> (view_w <= iw_q && view_h <= ih_q));

  // R1: none/fullscreen leave the size unchanged after underscan
  a_r1_plain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIT && (md_q == SCL_NONE || md_q == SCL_FULL)) |=>
      ($stable(view_w) && $stable(view_h)));
endmodule

// File: tb/vfit_viewport_tb_top.sv
`timescale 1ns/1ps
module vfit_viewport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] in_w = '0, in_h = '0, in_vtotal = '0, mode_w = '0, mode_h = '0;
  logic [15:0] border_h = '0, border_v = '0;
  logic        pack3d = 1'b0, force_full = 1'b0, underscan = 1'b0;
  logic [1:0]  scale_mode = '0;
  logic        busy, done;
  logic [16:0] view_w, view_h;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vfit_viewport dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_w(in_w), .in_h(in_h),
    .in_vtotal(in_vtotal), .pack3d(pack3d), .mode_w(mode_w), .mode_h(mode_h),
    .scale_mode(scale_mode), .force_full(force_full), .underscan(underscan),
    .border_h(border_h), .border_v(border_v),
    .busy(busy), .done(done), .view_w(view_w), .view_h(view_h)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: final size and done latency
  task automatic model(input longint iw_, input longint ih_, input longint vt, input bit pk,
                       input longint mw, input longint mh, input int sm, input bit ff,
                       input bit us, input longint hb, input longint vb,
                       output longint ew, output longint eh, output int lat);
    longint ihv, ow, oh, old, dec, r;
    int m;
    ihv = pk ? ih_ + vt : ih_;
    m = ff ? 1 : sm;
    if (!ff && sm == 0) begin ow = iw_; oh = ihv; end
    else begin ow = mw; oh = mh; end
    lat = 3;
    if (us) begin
      old = ow;
      dec = (hb != 0) ? 2 * hb : ow / 16 + 32;
      ow = (ow > dec) ? ow - dec : 0;
      if (vb != 0) begin
        dec = 2 * vb;
        oh = (oh > dec) ? oh - dec : 0;
      end else if (old == 0) begin
        lat += 1;
      end else begin
        r = (oh << 19) / old;
        oh = ((ow * r + r / 2) >> 19) & 64'h1FFFF;
        lat += 37;
      end
    end
    if (m == 2) begin
      if (iw_ < ow) ow = iw_;
      if (ihv < oh) oh = ihv;
    end else if (m == 3) begin
      if (ow * ihv > iw_ * oh) begin
        if (ihv == 0) lat += 1;
        else begin
          r = (iw_ << 19) / ihv;
          ow = ((oh * r + r / 2) >> 19) & 64'h1FFFF;
          lat += 37;
        end
      end else begin
        if (iw_ == 0) lat += 1;
        else begin
          r = (ihv << 19) / iw_;
          oh = ((ow * r + r / 2) >> 19) & 64'h1FFFF;
          lat += 37;
        end
      end
    end
    ew = ow;
    eh = oh;
  endtask

  task automatic run_case(input string req, input int iw_, input int ih_, input int vt,
                          input bit pk, input int mw, input int mh, input int sm,
                          input bit ff, input bit us, input int hb, input int vb,
                          input bit poke);
    longint ew, eh;
    int lat;
    model(iw_, ih_, vt, pk, mw, mh, sm, ff, us, hb, vb, ew, eh, lat);
    @(negedge clk);
    in_w = 16'(iw_); in_h = 16'(ih_); in_vtotal = 16'(vt); pack3d = pk;
    mode_w = 16'(mw); mode_h = 16'(mh); scale_mode = 2'(sm); force_full = ff;
    underscan = us; border_h = 16'(hb); border_v = 16'(vb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: operands change after capture; only the sampled ones count
    in_w = 16'hABCD; in_h = 16'h1234; in_vtotal = 16'h0777; pack3d = 1'b0;
    mode_w = 16'h0100; mode_h = 16'h0200; scale_mode = 2'd0; force_full = 1'b0;
    underscan = 1'b0; border_h = 16'd5; border_v = 16'd7;
    for (int n = 1; n <= lat; n++) begin
      if (poke && n == 4) start = 1'b1;
      if (poke && n == 5) start = 1'b0;
      check({req, " R9"}, "done timing", longint'(done), longint'(n == lat));
      if (n == lat) begin
        check(req, "view_w", longint'(view_w), ew);
        check(req, "view_h", longint'(view_h), eh);
      end
      if (n < lat) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check({req, " R10"}, "hold w", longint'(view_w), ew);
    check({req, " R10"}, "hold h", longint'(view_h), eh);
    check({req, " R10"}, "idle busy", longint'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "busy", longint'(busy), 0);
    check("R11", "done", longint'(done), 0);
    check("R11", "view_w", longint'(view_w), 0);
    check("R11", "view_h", longint'(view_h), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case("R1 none",       640, 480, 525, 0, 1920, 1080, 0, 0, 0, 0, 0, 0);
    run_case("R1 full",       640, 480, 525, 0, 1920, 1080, 1, 0, 0, 0, 0, 0);
    run_case("R1 forced",     640, 480, 525, 0, 1920, 1080, 2, 1, 0, 0, 0, 0);
    run_case("R2 stereo",    1280, 720, 750, 1, 1920, 1080, 0, 0, 0, 0, 0, 0);
    run_case("R3 R4 borders", 800, 600, 628, 0, 1920, 1080, 1, 0, 1, 20, 10, 0);
    run_case("R3 R4 auto",    800, 600, 628, 0, 1920, 1080, 1, 0, 1, 0, 0, 0);
    run_case("R3 R4 sat",     800, 600, 628, 0, 1920, 1080, 1, 0, 1, 1000, 600, 0);
    run_case("R5 center",    1800, 1200, 1250, 0, 1920, 1080, 2, 0, 0, 0, 0, 0);
    run_case("R7 und center",1800, 1200, 1250, 0, 1920, 1080, 2, 0, 1, 0, 0, 0);
    run_case("R6 widen",      640, 480, 525, 0, 1920, 1080, 3, 0, 0, 0, 0, 0);
    run_case("R6 tall",      1920, 800, 825, 0, 1280, 1024, 3, 0, 0, 0, 0, 0);
    run_case("R7 und aspect", 720, 576, 625, 0, 1920, 1080, 3, 0, 1, 0, 0, 1);
    run_case("R8 und zero",   640, 480, 525, 0, 0, 777, 1, 0, 1, 0, 0, 0);
    run_case("R8 asp zero",     0, 0, 0, 0, 100, 50, 3, 0, 0, 0, 0, 0);
    run_case("R10 poke",      640, 480, 525, 0, 1920, 1080, 3, 0, 1, 30, 0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule